// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the bus-facing controller of a byte-wide serial EEPROM, written as synthesizable logic. It samples the clock and data lines of a two-wire bus with a fast system clock. It drives the data line only through an open-drain pull-down enable. It recognises start and stop conditions and selects itself from a fixed four-bit device code plus three strap inputs, so that eight such devices can share one bus. It then takes a two-byte word address and either stores incoming bytes into its array or returns stored bytes to the bus controller.

Writes may hold one byte or a partial or full page. A write-protect input blocks them. After a stop that closes a write, an internal write timer keeps the device off the bus for a set number of system clocks. Reads may start at the current address, at a freshly loaded address (a write of the address followed by a repeated start), or run on sequentially. A start, nine clocks, a start and a stop bring the controller back to idle from any state.

Its state machine has these states. **IDLE** waits for a start. **DEV** shifts in the device byte. **DEV_ACK** acknowledges it. **AHI** and **AHI_ACK** handle the address high byte. **ALO** and **ALO_ACK** handle the address low byte. **WDATA** and **WDATA_ACK** handle write data. **RDATA** shifts a byte out. **RACK** samples the controller's acknowledge. **IGNORE** waits for the next start or stop.

The transitions are as follows. A start goes from any state to DEV, and a stop goes from any state to IDLE. After the eighth bit, DEV goes to DEV_ACK on a match or to IGNORE on a mismatch. DEV_ACK goes to RDATA for a read or to AHI for a write. AHI goes to AHI_ACK, then ALO, then ALO_ACK, then WDATA. WDATA and WDATA_ACK alternate. RDATA goes to RACK after eight bits. RACK goes back to RDATA on an acknowledge or to IGNORE on a no-acknowledge.

Top module: `twi_eeprom_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) moves the controller to receive a device byte from any state. A stop condition (SDA rising while SCL is high) returns it to idle. Bytes clocked while idle get no acknowledge.
- R2: The device byte is sampled MSB first. Bits 7:4 must be 1010, bits 3:1 must equal strap_i[2:1:0], and bit 0 selects read (1) or write (0). A matching byte is acknowledged by pulling SDA low through the whole ninth clock. A byte that does not match gets no acknowledge, and all further bytes are ignored until the next start.
- R3: The word address arrives as two bytes, high byte first. Only its low ADDR_BITS bits are kept.
- R4: Each data byte of a write is acknowledged and stored at the current address.
- R5: Successive write bytes go to consecutive addresses. The low log2(PAGE_BYTES) address bits wrap within the page. A write may stop after any number of bytes.
- R6: While wp_i is high, write bytes are still acknowledged, but the array is unchanged and no busy interval follows.
- R7: A stop that ends a write which stored at least one byte starts a busy interval of WRITE_CYCLES system clocks. During this interval a matching device byte is not acknowledged. After it, the device byte is acknowledged again.
- R8: A write of the word address, followed by a repeated start and a read device byte, returns the byte stored at that address.
- R9: A read started directly after the device byte returns the byte at the address that follows the last byte accessed.
- R10: During a read, each acknowledge from the controller moves on to the next address. The address wraps from the last array location to 0.
- R11: A no-acknowledge from the controller ends the read. The target releases SDA and leaves it released while clocks continue.
- R12: A start, nine clocks with SDA released, a start and a stop return the target to idle from any state. The next transaction then works normally.
- R13: The target changes its SDA drive only while SCL is low.
- R14: After reset, SDA is released and the device is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| strap_i | input | 3 | Device select strap values |
| wp_i | input | 1 | High blocks all writes to the array |

## Verification
The bench builds the block with ADDR_BITS = 8 and WRITE_CYCLES = 1000. The 256-byte array brings the wrap from the last location to 0 within reach of a two-byte sequential read, and it lets word-address high bits be checked for being ignored. A busy interval of 1000 clocks is longer than one device byte on the bench's bus timing, so a poll issued right after a write is refused. A wait of a little over 1000 clocks then shows the interval ending. The page size stays at its default of 32 bytes, so a six-byte write starting four bytes before a page end exercises the in-page wrap.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } twi_state_e;

    // Fixed upper nibble of the device select byte
    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES:0] scl_sr;
    logic [STAGES:0] sda_sr;
    logic            scl_prev;
    logic            sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[STAGES-1:0], scl_i};
            sda_sr <= {sda_sr[STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl  = scl_sr[STAGES-1];
    assign sda_lvl  = sda_sr[STAGES-1];
    assign scl_prev = scl_sr[STAGES];
    assign sda_prev = sda_sr[STAGES];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/twi_ee_mem.sv
module twi_ee_mem #(
    parameter int ADDR_BITS = 12,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [DATA_BITS-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_BITS-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/twi_ee_wtimer.sv
module twi_ee_wtimer #(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CNT_W'(WRITE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy_o = (remain != '0);

    // R7
    busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R7
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_ee_pkg::*;
#(
    parameter int ADDR_BITS    = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int PAGE_BITS = $clog2(PAGE_BYTES);
    localparam int BIT_W     = 4;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    twi_ee_pkg::twi_state_e state, state_n;
    logic [BIT_W-1:0]     bit_cnt;
    logic [7:0]           shreg;
    logic [7:0]           txreg;
    logic [7:0]           addr_hi;
    logic [ADDR_BITS-1:0] addr;
    logic                 rw_bit;
    logic                 host_ack;
    logic                 wrote;
    logic                 busy;
    logic [7:0]           rd_data;
    logic                 mem_we;
    logic                 byte_done;
    logic                 dev_match;
    logic                 bus_evt;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_ee_mem #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (shreg),
        .raddr (addr),
        .rdata (rd_data)
    );

    twi_ee_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_wtimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (stop_det && wrote),
        .busy_o  (busy)
    );

    assign bus_evt   = start_det | stop_det;
    assign byte_done = scl_fall && (bit_cnt == BIT_W'(8));
    assign dev_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i) && !busy;
    assign mem_we    = byte_done && (state == ST_WDATA) && !wp_i && !bus_evt;

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      state_n = ST_IDLE;
            ST_DEV:       if (byte_done) state_n = dev_match ? ST_DEV_ACK : ST_IGNORE;
            ST_DEV_ACK:   if (scl_fall)  state_n = rw_bit ? ST_RDATA : ST_AHI;
            ST_AHI:       if (byte_done) state_n = ST_AHI_ACK;
            ST_AHI_ACK:   if (scl_fall)  state_n = ST_ALO;
            ST_ALO:       if (byte_done) state_n = ST_ALO_ACK;
            ST_ALO_ACK:   if (scl_fall)  state_n = ST_WDATA;
            ST_WDATA:     if (byte_done) state_n = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall)  state_n = ST_WDATA;
            ST_RDATA:     if (scl_fall && bit_cnt == BIT_W'(7)) state_n = ST_RACK;
            ST_RACK:      if (scl_fall)  state_n = host_ack ? ST_RDATA : ST_IGNORE;
            ST_IGNORE:    state_n = ST_IGNORE;
            default:      state_n = ST_IDLE;
        endcase
        if (start_det) begin
            state_n = ST_DEV;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Bit counter and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
        end else if (bus_evt) begin
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                    end
                    if (scl_fall && state == ST_DEV_ACK && rw_bit) begin
                        txreg <= rd_data;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == BIT_W'(7)) begin
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            txreg   <= {txreg[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall && host_ack) begin
                        txreg <= rd_data;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Address pointer, direction and write bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            addr_hi  <= '0;
            rw_bit   <= 1'b0;
            host_ack <= 1'b0;
            wrote    <= 1'b0;
        end else begin
            if (stop_det) begin
                wrote <= 1'b0;
            end else if (mem_we) begin
                wrote <= 1'b1;
            end
            if (!bus_evt) begin
                if (byte_done) begin
                    case (state)
                        ST_DEV:   rw_bit  <= shreg[0];
                        ST_AHI:   addr_hi <= shreg;
                        ST_ALO:   addr    <= ADDR_BITS'({addr_hi, shreg});
                        ST_WDATA: addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
                        default: begin
                        end
                    endcase
                end
                if (state == ST_RDATA && scl_fall && bit_cnt == BIT_W'(7)) begin
                    addr <= addr + 1'b1;
                end
                if (state == ST_RACK && scl_rise) begin
                    host_ack <= ~sda_lvl;
                end
            end
        end
    end

    // Output process
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~txreg[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    // R13
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R1
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    // R1
    stop_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R11
    quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

    // R7
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> !busy);

endmodule

// File: tb/twi_eeprom_target_test.sv
module twi_eeprom_target_test;

    localparam int AW = 8;
    localparam int WC = 1000;
    localparam int Q  = 8;
    localparam int LIMIT = 190000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    // {write address, read-back address, data}
    localparam logic [39:0] VEC [0:5] = '{
        40'h0010_0010_A5,
        40'h0011_7711_3C,
        40'h00FF_00FF_81,
        40'h0000_8000_7E,
        40'h1F42_0042_C3,
        40'h0080_0080_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_ctl = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   r13_bad = 0;
    logic prev_oe = 1'b0;
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];

    always #2 clk = ~clk;

    assign sda_line = sda_ctl & ~sda_oe;

    twi_eeprom_target #(
        .ADDR_BITS(AW), .PAGE_BYTES(32), .WRITE_CYCLES(WC), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
    );

    // R13 monitor: drive changes seen while SCL is high
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && scl) r13_bad++;
        end
        prev_oe <= sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_ctl = 1'b1; tick(Q);
        scl = 1'b1;     tick(Q);
        sda_ctl = 1'b0; tick(Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        sda_ctl = 1'b0; tick(Q);
        scl = 1'b1;     tick(Q);
        sda_ctl = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_ctl = b; tick(Q);
        scl = 1'b1;  tick(Q);
        r = sda_line;
        scl = 1'b0;  tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            d = {d[6:0], r};
        end
        clock_bit(give_ack ? 1'b0 : 1'b1, r);
        sda_ctl = 1'b1;
    endtask

    task automatic wr_bytes(input logic [15:0] a, input int n, output bit ok);
        bit k;
        ok = 1'b1;
        bus_start();
        send_byte(DEV_W, k);   ok &= k;
        send_byte(a[15:8], k); ok &= k;
        send_byte(a[7:0], k);  ok &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); ok &= k;
        end
        bus_stop();
    endtask

    task automatic rd_tail(input int n);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic rd_random(input logic [15:0] a, input int n, output bit ok);
        bit k;
        ok = 1'b1;
        bus_start();
        send_byte(DEV_W, k);   ok &= k;
        send_byte(a[15:8], k); ok &= k;
        send_byte(a[7:0], k);  ok &= k;
        bus_start();
        send_byte(DEV_R, k);   ok &= k;
        rd_tail(n);
    endtask

    task automatic rd_current(input int n, output bit ok);
        bit k;
        bus_start();
        send_byte(DEV_R, k);
        ok = k;
        rd_tail(n);
    endtask

    initial begin
        bit ok;
        bit k;
        logic r;
        logic [7:0] d;
        int zeros;

        tick(5);
        check(sda_oe == 1'b0, "R14 reset release", sda_oe, 0);
        rst_n = 1'b1;
        tick(10);

        // R14: not busy after reset
        bus_start();
        send_byte(DEV_W, k);
        check(k, "R14 first select acked", k, 1);
        bus_stop();
        tick(Q);

        // Table walk: byte write then random read back (R4 R8 R3)
        for (int i = 0; i < 6; i++) begin
            wbuf[0] = VEC[i][7:0];
            wr_bytes(VEC[i][39:24], 1, ok);
            check(ok, "R4 write acked", ok, 1);
            tick(WC + 100);
            rd_random(VEC[i][23:8], 1, ok);
            check(ok && rbuf[0] == VEC[i][7:0], "R8 R3 read back", rbuf[0], VEC[i][7:0]);
        end

        // R2: strap mismatch and code mismatch
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, k);
        check(!k, "R2 strap mismatch nack", k, 0);
        send_byte(8'h00, k);
        check(!k, "R2 ignored until start", k, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, k);
        check(!k, "R2 code mismatch nack", k, 0);
        bus_stop();

        // R7: busy interval after a write
        wbuf[0] = 8'h5A;
        wr_bytes(16'h0030, 1, ok);
        bus_start();
        send_byte(DEV_W, k);
        check(!k, "R7 busy refuses select", k, 0);
        bus_stop();
        tick(WC + 100);
        bus_start();
        send_byte(DEV_W, k);
        check(k, "R7 select acked after interval", k, 1);
        bus_stop();
        rd_random(16'h0030, 1, ok);
        check(rbuf[0] == 8'h5A, "R4 stored", rbuf[0], 8'h5A);

        // R6: write protect
        wp = 1'b1;
        wbuf[0] = 8'hEE;
        wr_bytes(16'h0010, 1, ok);
        check(ok, "R6 protected bytes acked", ok, 1);
        bus_start();
        send_byte(DEV_W, k);
        check(k, "R6 no busy interval", k, 1);
        bus_stop();
        rd_random(16'h0010, 1, ok);
        check(rbuf[0] == 8'hA5, "R6 array unchanged", rbuf[0], 8'hA5);
        wp = 1'b0;

        // R5: page write wrapping inside the page
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        wr_bytes(16'h003C, 6, ok);
        check(ok, "R5 page bytes acked", ok, 1);
        tick(WC + 100);
        rd_random(16'h003C, 4, ok);
        check(rbuf[0] == 8'h11 && rbuf[3] == 8'h44, "R5 page tail", {rbuf[0], rbuf[3]}, 16'h1144);
        rd_random(16'h0020, 2, ok);
        check(rbuf[0] == 8'h55 && rbuf[1] == 8'h66, "R5 page wrap", {rbuf[0], rbuf[1]}, 16'h5566);

        // R9: current address read
        wbuf[0] = 8'hAB; wbuf[1] = 8'hCD;
        wr_bytes(16'h0050, 2, ok);
        tick(WC + 100);
        rd_random(16'h0050, 1, ok);
        check(rbuf[0] == 8'hAB, "R9 setup read", rbuf[0], 8'hAB);
        rd_current(1, ok);
        check(ok && rbuf[0] == 8'hCD, "R9 current address", rbuf[0], 8'hCD);

        // R10: sequential read wraps at end of array
        rd_random(16'h00FF, 2, ok);
        check(rbuf[0] == 8'h81 && rbuf[1] == 8'h7E, "R10 array wrap", {rbuf[0], rbuf[1]}, 16'h817E);

        // R11: read ends on nack, SDA stays released
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        send_byte(8'h11, k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        check(d == 8'h3C, "R11 last byte", d, 8'h3C);
        zeros = 0;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, r);
            if (!r) zeros++;
        end
        check(zeros == 0, "R11 released after nack", zeros, 0);
        bus_stop();

        // R1: bytes without a start are ignored; repeated start mid-byte
        bus_start();
        send_byte(DEV_W, k);
        send_byte(8'h00, k);
        bus_stop();
        send_byte(DEV_W, k);
        check(!k, "R1 no start no ack", k, 0);
        bus_stop();
        bus_start();
        send_byte(DEV_W, k);
        for (int i = 0; i < 3; i++) clock_bit(1'b0, r);
        bus_start();
        send_byte(DEV_R, k);
        check(k, "R1 restart mid-byte", k, 1);
        recv_byte(1'b0, d);
        bus_stop();

        // R12: recovery sequence from the middle of an address byte
        bus_start();
        send_byte(DEV_W, k);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, r);
        bus_start();
        for (int i = 0; i < 9; i++) clock_bit(1'b1, r);
        bus_start();
        bus_stop();
        rd_random(16'h0050, 1, ok);
        check(ok && rbuf[0] == 8'hAB, "R12 recovered", rbuf[0], 8'hAB);

        check(r13_bad == 0, "R13 drive changes only with SCL low", r13_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule